// File: doc/BRIEF.md
# Write-Lock Command Sequence Detector

This block sits beside the write controller of a paged non-volatile memory. It watches each byte the controller loads into its page buffer and looks for the address/data patterns that switch a software write lock on or off. It holds the lock state. For every loaded byte it reports whether that byte may be committed to the array, or whether it is a command byte that must be withheld.

A load window is the run of byte loads that ends when the write controller raises `win_end`. Recognition always starts at the first byte of a window. The unlock prefix is 0xAA at 0x5555, then 0x55 at 0x2AAA, then 0xA0 at 0x5555. It arms the lock and also opens the window for data. The release sequence is six bytes: 0xAA at 0x5555, 0x55 at 0x2AAA, 0x80 at 0x5555, 0xAA at 0x5555, 0x55 at 0x2AAA and 0x20 at 0x5555. A change to the lock state is staged during the window and applied only when the window closes. While the lock is set, a window that does not start with the unlock prefix commits nothing. The write controller still runs its full write cycle for such a window.

The lock register is cleared only by the power-on reset input `por`. The ordinary reset `rst` clears the sequence tracking and the per-byte verdicts but leaves the lock untouched. Both resets are synchronous and active high.

Top module: `wp_seq_detect`

## Requirements
- R1: While `por` is high, `lock` is cleared to 0 and stays 0 until a release or arm takes effect. Asserting `rst` alone never changes `lock`.
- R2: For every cycle with `ld_stb` high, `vrd_vld` is 1 in the following cycle, and `commit_en`/`cmd_mask` then give the verdict on that byte. In cycles not preceded by a strobe, all three outputs are 0.
- R3: The unlock prefix bytes (0xAA@0x5555, 0x55@0x2AAA, 0xA0@0x5555, all 15 address bits compared) give `cmd_mask`=1 and `commit_en`=0. When the prefix is seen, `lock` becomes 1 in the cycle after `win_end`.
- R4: The six release bytes (0xAA@0x5555, 0x55@0x2AAA, 0x80@0x5555, 0xAA@0x5555, 0x55@0x2AAA, 0x20@0x5555) are each masked and never committed. Once all six are seen, `lock` becomes 0 in the cycle after `win_end`. No data bytes need to follow.
- R5: While `lock`=1, bytes after a complete unlock prefix in the same window give `commit_en`=1, and `lock` stays 1 after the window closes.
- R6: While `lock`=1, every byte of a window that does not begin with a command sequence gives `commit_en`=0 and `cmd_mask`=0.
- R7: While `lock`=0, a byte that is not a command byte gives `commit_en`=1.
- R8: A byte that breaks a partly matched sequence, and every later byte of that window, counts as ordinary data under the current `lock`. Bytes that matched before the break stay masked, and `lock` is unchanged when the window closes.
- R9: Command addresses hold ordinary data. A byte such as 0xAA@0x5555 that is not at the position the tracker expects gives `cmd_mask`=0 and is judged as data.
- R10: `lock` changes only in the cycle after `win_end` (or under `por`). Throughout a window it keeps its value from the start of the window.
- R11: `cmd_mask` and `commit_en` are never both 1.
- R12: When `ld_stb` and `win_end` are high in the same cycle, that byte is the last of its window and counts toward any pending change. The next strobe starts a fresh match at the first position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset of tracking and verdicts; lock kept |
| por | input | 1 | Synchronous power-on reset; clears the lock |
| ld_stb | input | 1 | One-cycle pulse per byte loaded into the page buffer |
| ld_addr | input | 15 | Low address bits of the loaded byte |
| ld_data | input | 8 | Loaded data byte |
| win_end | input | 1 | Load window closes; staged lock change is applied |
| lock | output | 1 | Current write-lock state |
| vrd_vld | output | 1 | Verdict for the byte strobed in the previous cycle is valid |
| commit_en | output | 1 | That byte may be written to the array |
| cmd_mask | output | 1 | That byte is a command byte and is withheld |

## Verification
The assertions check on every cycle that verdicts appear only after a strobe, that `cmd_mask` and `commit_en` are exclusive, and that a non-command byte under a clear lock is committed. They also check that `lock` moves only after `win_end`, and that an arm and a release are never staged together. Only the bench scenarios can show which patterns count as commands: the exact address and data at each step of both sequences, the break at each position, the full sweep of data values at 0x5555 under both lock states, the survival of the lock across `rst`, and the handling of a strobe that shares its cycle with `win_end`.

// File: rtl/wp_seq_pkg.sv
package wp_seq_pkg;

  // Number of steps in the longest (release) sequence.
  localparam int NSTEP = 6;
  localparam int SW    = $clog2(NSTEP);

  // Positions 0..5 walk the command steps; the two tail states cover the
  // remainder of a window that opened for data or fell back to plain data.
  typedef enum logic [2:0] {
    ST_K0    = 3'd0,
    ST_K1    = 3'd1,
    ST_K2    = 3'd2,
    ST_K3    = 3'd3,
    ST_K4    = 3'd4,
    ST_K5    = 3'd5,
    ST_OPEN  = 3'd6,
    ST_PLAIN = 3'd7
  } wp_state_e;

endpackage

// File: rtl/wp_step_match.sv
module wp_step_match #(
  parameter int          AW       = 15,
  parameter int          DW       = 8,
  parameter logic [AW-1:0] ADDR_A = 15'h5555,
  parameter logic [AW-1:0] ADDR_B = 15'h2AAA,
  parameter logic [DW-1:0] KEY1   = 8'hAA,
  parameter logic [DW-1:0] KEY2   = 8'h55,
  parameter logic [DW-1:0] KEY_ON = 8'hA0,
  parameter logic [DW-1:0] KEY_X1 = 8'h80,
  parameter logic [DW-1:0] KEY_X2 = 8'h20
) (
  input  logic [AW-1:0]                addr,
  input  logic [DW-1:0]                data,
  output logic [wp_seq_pkg::NSTEP-1:0] hit,
  output logic                         hit_on
);
  import wp_seq_pkg::*;

  function automatic logic [AW-1:0] step_addr(input int i);
    return (i == 1 || i == 4) ? ADDR_B : ADDR_A;
  endfunction

  function automatic logic [DW-1:0] step_data(input int i);
    case (i)
      0, 3:    return KEY1;
      1, 4:    return KEY2;
      2:       return KEY_X1;
      default: return KEY_X2;
    endcase
  endfunction

  // One comparator per step of the release sequence.
  for (genvar g = 0; g < NSTEP; g++) begin : g_step
    localparam logic [AW-1:0] EA = step_addr(g);
    localparam logic [DW-1:0] ED = step_data(g);
    assign hit[g] = (addr == EA) && (data == ED);
  end

  // Third step alternative that completes the unlock prefix.
  assign hit_on = (addr == ADDR_A) && (data == KEY_ON);

endmodule

// File: rtl/wp_seq_fsm.sv
module wp_seq_fsm (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         ld_stb,
  input  logic                         win_end,
  input  logic                         lock,
  input  logic [wp_seq_pkg::NSTEP-1:0] hit,
  input  logic                         hit_on,
  output logic                         cmd_c,
  output logic                         commit_c,
  output logic                         req_on,
  output logic                         req_off
);
  import wp_seq_pkg::*;

  wp_state_e      state, nxt;
  logic           pend_on, pend_off;
  logic           got_on, got_off;
  logic [SW-1:0]  step_idx;

  assign step_idx = state[SW-1:0];

  always_comb begin
    nxt      = state;
    cmd_c    = 1'b0;
    commit_c = 1'b0;
    got_on   = 1'b0;
    got_off  = 1'b0;
    if (ld_stb) begin
      case (state)
        ST_OPEN:  commit_c = 1'b1;
        ST_PLAIN: commit_c = !lock;
        default: begin
          if (state == ST_K2 && hit_on) begin
            cmd_c  = 1'b1;
            got_on = 1'b1;
            nxt    = ST_OPEN;
          end else if (hit[step_idx]) begin
            cmd_c = 1'b1;
            if (state == ST_K5) begin
              got_off = 1'b1;
              nxt     = ST_OPEN;
            end else begin
              nxt = wp_state_e'(state + 3'd1);
            end
          end else begin
            commit_c = !lock;
            nxt      = ST_PLAIN;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_K0;
      pend_on  <= 1'b0;
      pend_off <= 1'b0;
    end else if (win_end) begin
      state    <= ST_K0;
      pend_on  <= 1'b0;
      pend_off <= 1'b0;
    end else if (ld_stb) begin
      state    <= nxt;
      pend_on  <= pend_on  | got_on;
      pend_off <= pend_off | got_off;
    end
  end

  assign req_on  = win_end && (pend_on  || got_on);
  assign req_off = win_end && (pend_off || got_off);

  // R3 R4: one window stages at most one kind of lock change.
  a_r4_single_pending: assert property (@(posedge clk) disable iff (rst)
    !(pend_on && pend_off));

  // R8: once a window falls back to plain data it never masks again.
  a_r8_plain_sticky: assert property (@(posedge clk) disable iff (rst)
    (state == ST_PLAIN && !win_end) |=> (state == ST_PLAIN));

endmodule

// File: rtl/wp_lock_reg.sv
module wp_lock_reg (
  input  logic clk,
  input  logic por,
  input  logic req_on,
  input  logic req_off,
  output logic lock
);

  // Cleared only by power-on reset; survives the ordinary reset.
  always_ff @(posedge clk) begin
    if (por)          lock <= 1'b0;
    else if (req_off) lock <= 1'b0;
    else if (req_on)  lock <= 1'b1;
  end

endmodule

// File: rtl/wp_seq_detect.sv
module wp_seq_detect #(
  parameter int            AW     = 15,
  parameter int            DW     = 8,
  parameter logic [AW-1:0] ADDR_A = 15'h5555,
  parameter logic [AW-1:0] ADDR_B = 15'h2AAA
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          por,
  input  logic          ld_stb,
  input  logic [AW-1:0] ld_addr,
  input  logic [DW-1:0] ld_data,
  input  logic          win_end,
  output logic          lock,
  output logic          vrd_vld,
  output logic          commit_en,
  output logic          cmd_mask
);
  import wp_seq_pkg::*;

  logic [NSTEP-1:0] hit;
  logic             hit_on;
  logic             cmd_c, commit_c, req_on, req_off;

  wp_step_match #(
    .AW(AW), .DW(DW), .ADDR_A(ADDR_A), .ADDR_B(ADDR_B)
  ) u_match (
    .addr   (ld_addr),
    .data   (ld_data),
    .hit    (hit),
    .hit_on (hit_on)
  );

  wp_seq_fsm u_fsm (
    .clk      (clk),
    .rst      (rst),
    .ld_stb   (ld_stb),
    .win_end  (win_end),
    .lock     (lock),
    .hit      (hit),
    .hit_on   (hit_on),
    .cmd_c    (cmd_c),
    .commit_c (commit_c),
    .req_on   (req_on),
    .req_off  (req_off)
  );

  wp_lock_reg u_lock (
    .clk     (clk),
    .por     (por),
    .req_on  (req_on),
    .req_off (req_off),
    .lock    (lock)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      vrd_vld   <= 1'b0;
      commit_en <= 1'b0;
      cmd_mask  <= 1'b0;
    end else begin
      vrd_vld   <= ld_stb;
      commit_en <= commit_c;
      cmd_mask  <= cmd_c;
    end
  end

  // R2: a verdict only ever follows a strobe.
  a_r2_vld_after_stb: assert property (@(posedge clk) disable iff (rst)
    (vrd_vld || commit_en || cmd_mask) |-> $past(ld_stb));

  // R11: a byte is never both withheld and committed.
  a_r11_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(cmd_mask && commit_en));

  // R7: with the lock clear, a non-command byte is committed.
  a_r7_open_commit: assert property (@(posedge clk) disable iff (rst || por)
    (vrd_vld && !cmd_mask && !$past(lock)) |-> commit_en);

  // R10: the lock moves only in the cycle after a window closes.
  a_r10_lock_at_end: assert property (@(posedge clk) disable iff (por)
    !$stable(lock) |-> $past(win_end));

endmodule

// File: tb/wp_seq_detect_tb.sv
`timescale 1ns/1ps
module wp_seq_detect_tb_top;

  logic        clk = 1'b0;
  logic        rst, por, ld_stb, win_end;
  logic [14:0] ld_addr;
  logic [7:0]  ld_data;
  logic        lock, vrd_vld, commit_en, cmd_mask;

  int  n_chk = 0;
  int  n_bad = 0;
  int  cyc   = 0;
  bit  done  = 1'b0;
  bit  exp_lock;

  always #4 clk = ~clk;

  wp_seq_detect dut_i (
    .clk(clk), .rst(rst), .por(por), .ld_stb(ld_stb), .ld_addr(ld_addr),
    .ld_data(ld_data), .win_end(win_end), .lock(lock), .vrd_vld(vrd_vld),
    .commit_en(commit_en), .cmd_mask(cmd_mask)
  );

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !done) begin
      n_bad = n_bad + 1;
      $display("FAIL watchdog: got cycle %0d exp done", cyc);
      summary();
      $finish;
    end
  end

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0h exp %0h", req, what, act, exp);
    end
  endtask

  // Load one byte and check the verdict one cycle later.
  task automatic load(input logic [14:0] a, input logic [7:0] d,
                      input bit e_cmd, input bit e_commit,
                      input string req, input bit last = 1'b0);
    @(negedge clk);
    ld_stb = 1'b1; ld_addr = a; ld_data = d; win_end = last;
    @(negedge clk);
    ld_stb = 1'b0; win_end = 1'b0;
    check(req, "vrd_vld", 32'(vrd_vld), 32'd1);
    check(req, "cmd_mask", 32'(cmd_mask), 32'(e_cmd));
    check(req, "commit_en", 32'(commit_en), 32'(e_commit));
  endtask

  task automatic close_win();
    @(negedge clk);
    win_end = 1'b1;
    @(negedge clk);
    win_end = 1'b0;
  endtask

  function automatic logic [14:0] rel_a(input int i);
    return (i == 1 || i == 4) ? 15'h2AAA : 15'h5555;
  endfunction

  function automatic logic [7:0] rel_d(input int i);
    case (i)
      0, 3:    return 8'hAA;
      1, 4:    return 8'h55;
      2:       return 8'h80;
      default: return 8'h20;
    endcase
  endfunction

  task automatic unlock_prefix(input string req, input bit last_end = 1'b0);
    load(15'h5555, 8'hAA, 1, 0, req);
    load(15'h2AAA, 8'h55, 1, 0, req);
    load(15'h5555, 8'hA0, 1, 0, req, last_end);
  endtask

  task automatic release_seq(input string req);
    for (int i = 0; i < 6; i++) load(rel_a(i), rel_d(i), 1, 0, req);
  endtask

  // Break the release sequence at each position k.
  task automatic break_sweep();
    for (int k = 0; k < 6; k++) begin
      for (int j = 0; j < k; j++) load(rel_a(j), rel_d(j), 1, 0, "R8");
      load(15'h0100, 8'h11, 0, !exp_lock, "R8");
      load(15'h5555, 8'hAA, 0, !exp_lock, "R8");
      close_win();
      check("R8", "lock", 32'(lock), 32'(exp_lock));
    end
  endtask

  // Single-byte windows at the first command address, all data values.
  task automatic data_sweep();
    for (int v = 0; v < 256; v++) begin
      bit is_key = (v == 8'hAA);
      load(15'h5555, 8'(v), is_key, !is_key && !exp_lock, "R9");
      close_win();
    end
    check("R10", "lock", 32'(lock), 32'(exp_lock));
  endtask

  initial begin
    rst = 1'b1; por = 1'b1; ld_stb = 1'b0; win_end = 1'b0;
    ld_addr = '0; ld_data = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0; por = 1'b0;
    @(negedge clk);
    exp_lock = 1'b0;
    check("R1", "lock", 32'(lock), 32'd0);
    check("R2", "vrd_vld idle", 32'(vrd_vld), 32'd0);

    // R7: plain byte with lock clear; R2: verdict lasts one cycle.
    load(15'h1234, 8'h3C, 0, 1, "R7");
    @(negedge clk);
    check("R2", "vrd_vld drop", 32'(vrd_vld), 32'd0);
    close_win();

    data_sweep();

    // R9: key byte at a non-start position is data.
    load(15'h0000, 8'h00, 0, 1, "R9");
    load(15'h5555, 8'hAA, 0, 1, "R9");
    close_win();

    // R3 + R10: arm with data; lock holds until window closes.
    unlock_prefix("R3");
    load(15'h0040, 8'h5A, 0, 1, "R3");
    check("R10", "lock mid", 32'(lock), 32'd0);
    close_win();
    exp_lock = 1'b1;
    check("R3", "lock", 32'(lock), 32'd1);

    // R1: ordinary reset keeps the lock.
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    check("R1", "lock after rst", 32'(lock), 32'd1);

    // R6: locked, no prefix.
    load(15'h0200, 8'h77, 0, 0, "R6");
    load(15'h0201, 8'h78, 0, 0, "R6");
    close_win();
    check("R6", "lock", 32'(lock), 32'd1);

    // R5: locked, prefix then data.
    unlock_prefix("R5");
    load(15'h0300, 8'h12, 0, 1, "R5");
    load(15'h0301, 8'h34, 0, 1, "R5");
    close_win();
    check("R5", "lock", 32'(lock), 32'd1);

    data_sweep();
    break_sweep();

    // R4: release with no data bytes.
    release_seq("R4");
    check("R10", "lock mid", 32'(lock), 32'd1);
    close_win();
    exp_lock = 1'b0;
    check("R4", "lock", 32'(lock), 32'd0);

    break_sweep();

    // R12: last prefix byte shares its cycle with win_end.
    unlock_prefix("R12", 1'b1);
    exp_lock = 1'b1;
    check("R12", "lock", 32'(lock), 32'd1);
    load(15'h2AAA, 8'h55, 0, 0, "R12");
    close_win();

    // R4: release followed by data, which is committed.
    release_seq("R4");
    load(15'h0400, 8'h9E, 0, 1, "R4");
    close_win();
    exp_lock = 1'b0;
    check("R4", "lock", 32'(lock), 32'd0);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule